// File: doc/BRIEF.md
# Ring Write Address Wrapper

This block sits on the write path of a quadword DMA channel that moves data out of a 16 KB local scratchpad into main memory. Each burst request carries a destination byte address, a scratchpad pointer and a remaining quadword count. The block clips the burst so that it stops at the scratchpad end. It then works out where the channel's two pointers land after the burst. When the destination lies inside a ring buffer, the new destination is folded back into the ring by a base-plus-masked-offset rule. A register write port sets the ring's base and mask.

Quadwords written inside the ring area are added to a running total. The last burst of a transfer leaves nothing remaining. When that burst has a non-zero total, the block emits a one-cycle resume pulse that carries the total, so the ring's consumer knows how much new data it can drain. The total is then cleared.

Requests and results are valid/ready streams. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high when the result slot is empty or is being emptied in the same cycle. A result stays on the outputs, unchanged, until `out_ready` accepts it.

Top module: `ring_wrap`

## Requirements
- R1: After reset, `out_valid`, `resume_pulse` and `ring_total` are 0 and `req_ready` is 1.
- R2: A configuration write with `cfg_sel`=0 sets the ring base, and one with `cfg_sel`=1 sets the ring mask. The low 4 bits of the written value are stored as zero. The low 4 bits of `req_madr` and `req_sadr` are treated as zero.
- R3: A destination is in the ring (`out_in_ring`=1) when it is at or above the base and below base + mask + 16.
- R4: Outside bypass, the burst length is the smaller of `req_qwc` and 1024 − `req_sadr[13:4]`, and `out_remain` = `req_qwc` − burst.
- R5: In the ring with a non-zero mask, the next destination is base + ((madr + burst×16) AND mask). Outside the ring, it is madr + burst×16.
- R6: In the ring with a non-zero mask, if (madr AND NOT mask) differs from the base, `out_stray`=1 and the burst is not added to the running total.
- R7: In the ring with a zero mask (bypass), the burst length is the whole `req_qwc`, the remainder is 0, the destination advances by `req_qwc`×16 and nothing is counted.
- R8: The next scratchpad pointer is (`req_sadr` + burst×16) AND 0x3FFF.
- R9: Quadwords of counted ring bursts accumulate in `ring_total`.
- R10: When a burst has a remainder of 0 and the total including it is non-zero, `resume_pulse` is high for exactly the cycle after acceptance, `resume_qwc` carries that total, and `ring_total` reads 0.
- R11: `req_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, the result outputs stay unchanged.
- R12: A request with `req_qwc`=0 gives a burst of 0 and leaves both pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = ring base, 1 = ring mask |
| cfg_wdata | input | ADDR_W | Configuration write value |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_madr | input | ADDR_W | Destination byte address |
| req_sadr | input | SP_W | Scratchpad byte pointer |
| req_qwc | input | QWC_W | Remaining quadword count |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| out_burst | output | QWC_W | Clipped burst length in quadwords |
| out_remain | output | QWC_W | Quadwords left after the burst |
| out_madr_next | output | ADDR_W | Destination after the burst |
| out_sadr_next | output | SP_W | Scratchpad pointer after the burst |
| out_in_ring | output | 1 | Destination was inside the ring window |
| out_stray | output | 1 | Ring write outside the aligned ring area |
| ring_total | output | TOT_W | Running counted quadword total |
| resume_pulse | output | 1 | One-cycle resume strobe to the consumer |
| resume_qwc | output | TOT_W | Total handed over with the resume strobe |

## Verification
Every cycle, the assertions check that a held result does not change under back-pressure and that ready follows the rule in R11. They also check that a clipped burst never passes the scratchpad end or the request count, that bypass passes the whole count, that the total grows by exactly the counted burst, and that a resume leaves the total at zero. The arithmetic needs the bench's scenarios: ring membership at the window edges, the masked fold-back of the destination, the stray-write detection with a misaligned base, and a transfer split across two bursts at the scratchpad end. So do totals that span several bursts, the 0x3FFF pointer wrap and the zero-count request.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_MASK = 1'b1
  } cfg_sel_e;

  localparam int QW_SHIFT = 4;
endpackage

// File: rtl/rbw_window.sv
module rbw_window #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] madr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              in_ring,
  output logic              bypass
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] limit;

  always_comb begin
    limit   = {1'b0, base} + {1'b0, mask} + EXT_W'(16);
    in_ring = (madr >= base) && ({1'b0, madr} < limit);
    bypass  = in_ring && (mask == '0);
  end
endmodule

// File: rtl/rbw_clip.sv
module rbw_clip #(
  parameter int QWC_W = 16,
  parameter int SP_W  = 14
) (
  input  logic [QWC_W-1:0] qwc,
  input  logic [SP_W-1:0]  sadr,
  input  logic             bypass,
  output logic [QWC_W-1:0] burst,
  output logic [QWC_W-1:0] remain,
  output logic [SP_W-1:0]  next_sadr
);
  localparam int IDX_W  = SP_W - 4;
  localparam int ROOM_W = IDX_W + 1;

  logic [ROOM_W-1:0] room;
  logic [QWC_W-1:0]  room_q;
  logic [QWC_W+3:0]  bytes;

  always_comb begin
    room      = ROOM_W'(1 << IDX_W) - ROOM_W'(sadr[SP_W-1:4]);
    room_q    = QWC_W'(room);
    if (bypass)
      burst = qwc;
    else
      burst = (qwc < room_q) ? qwc : room_q;
    remain    = qwc - burst;
    bytes     = {burst, 4'b0000};
    next_sadr = sadr + bytes[SP_W-1:0];
  end
endmodule

// File: rtl/rbw_wrap.sv
module rbw_wrap #(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16
) (
  input  logic [ADDR_W-1:0] madr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic              in_ring,
  input  logic              bypass,
  input  logic [QWC_W-1:0]  burst,
  output logic [ADDR_W-1:0] next_madr,
  output logic              stray,
  output logic              count_en
);
  logic              ring_mode;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] adv;

  always_comb begin
    ring_mode = in_ring && !bypass;
    step      = ADDR_W'({burst, 4'b0000});
    adv       = madr + step;
    next_madr = ring_mode ? (base + (adv & mask)) : adv;
    stray     = ring_mode && ((madr & ~mask) != base);
    count_en  = ring_mode && !stray;
  end
endmodule

// File: rtl/rbw_tally.sv
module rbw_tally #(
  parameter int QWC_W = 16,
  parameter int TOT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             add_en,
  input  logic [QWC_W-1:0] add,
  input  logic             last,
  output logic [TOT_W-1:0] total_q,
  output logic             pulse_q,
  output logic [TOT_W-1:0] pulse_qwc_q
);
  logic [TOT_W-1:0] sum;

  always_comb sum = total_q + (add_en ? TOT_W'(add) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q     <= '0;
      pulse_q     <= 1'b0;
      pulse_qwc_q <= '0;
    end else begin
      pulse_q <= 1'b0;
      if (fire) begin
        if (last && (sum != '0)) begin
          pulse_q     <= 1'b1;
          pulse_qwc_q <= sum;
          total_q     <= '0;
        end else begin
          total_q <= sum;
        end
      end
    end
  end

  // R10: a resume strobe coincides with an emptied total
  a_r10_clear_on_resume: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (total_q == '0));

  // R9: a counted, non-final burst grows the total by exactly its length
  a_r9_total_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && add_en && !last) |=> (total_q == $past(total_q) + TOT_W'($past(add))));
endmodule

// File: rtl/ring_wrap.sv
module ring_wrap
  import rbw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16,
  parameter int SP_W   = 14,
  parameter int TOT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_madr,
  input  logic [SP_W-1:0]   req_sadr,
  input  logic [QWC_W-1:0]  req_qwc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [QWC_W-1:0]  out_burst,
  output logic [QWC_W-1:0]  out_remain,
  output logic [ADDR_W-1:0] out_madr_next,
  output logic [SP_W-1:0]   out_sadr_next,
  output logic              out_in_ring,
  output logic              out_stray,
  output logic [TOT_W-1:0]  ring_total,
  output logic              resume_pulse,
  output logic [TOT_W-1:0]  resume_qwc
);
  localparam logic [ADDR_W-1:0] A_LOW = ADDR_W'((1 << QW_SHIFT) - 1);
  localparam logic [SP_W-1:0]   S_LOW = SP_W'((1 << QW_SHIFT) - 1);
  localparam int                SP_QW = 1 << (SP_W - QW_SHIFT);

  logic [ADDR_W-1:0] base_q, mask_q;
  logic [ADDR_W-1:0] madr_a;
  logic [SP_W-1:0]   sadr_a;
  logic              fire;
  logic              in_ring, bypass, stray, count_en;
  logic [QWC_W-1:0]  burst, remain;
  logic [SP_W-1:0]   next_sadr;
  logic [ADDR_W-1:0] next_madr;
  logic              out_valid_q;

  // configuration registers, quadword aligned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel_e'(cfg_sel) == SEL_BASE)
        base_q <= cfg_wdata & ~A_LOW;
      else
        mask_q <= cfg_wdata & ~A_LOW;
    end
  end

  always_comb begin
    madr_a    = req_madr & ~A_LOW;
    sadr_a    = req_sadr & ~S_LOW;
    req_ready = !out_valid_q || out_ready;
    fire      = req_valid && req_ready;
  end

  rbw_window #(.ADDR_W(ADDR_W)) u_window (
    .madr    (madr_a),
    .base    (base_q),
    .mask    (mask_q),
    .in_ring (in_ring),
    .bypass  (bypass)
  );

  rbw_clip #(.QWC_W(QWC_W), .SP_W(SP_W)) u_clip (
    .qwc       (req_qwc),
    .sadr      (sadr_a),
    .bypass    (bypass),
    .burst     (burst),
    .remain    (remain),
    .next_sadr (next_sadr)
  );

  rbw_wrap #(.ADDR_W(ADDR_W), .QWC_W(QWC_W)) u_wrap (
    .madr      (madr_a),
    .base      (base_q),
    .mask      (mask_q),
    .in_ring   (in_ring),
    .bypass    (bypass),
    .burst     (burst),
    .next_madr (next_madr),
    .stray     (stray),
    .count_en  (count_en)
  );

  rbw_tally #(.QWC_W(QWC_W), .TOT_W(TOT_W)) u_tally (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .add_en      (count_en),
    .add         (burst),
    .last        (remain == '0),
    .total_q     (ring_total),
    .pulse_q     (resume_pulse),
    .pulse_qwc_q (resume_qwc)
  );

  // result slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q   <= 1'b0;
      out_burst     <= '0;
      out_remain    <= '0;
      out_madr_next <= '0;
      out_sadr_next <= '0;
      out_in_ring   <= 1'b0;
      out_stray     <= 1'b0;
    end else if (fire) begin
      out_valid_q   <= 1'b1;
      out_burst     <= burst;
      out_remain    <= remain;
      out_madr_next <= next_madr;
      out_sadr_next <= next_sadr;
      out_in_ring   <= in_ring;
      out_stray     <= stray;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;

  // R11: a stalled result is held steady
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_burst) && $stable(out_remain)
      && $stable(out_madr_next) && $stable(out_sadr_next) && $stable(out_stray)));

  // R11: an empty slot always takes a request
  a_r11_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> req_ready);

  // R4: a clipped burst stays inside the request and the scratchpad
  a_r4_clip_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !bypass) |-> ((burst <= req_qwc) &&
      ((QWC_W+1)'(sadr_a[SP_W-1:QW_SHIFT]) + (QWC_W+1)'(burst) <= (QWC_W+1)'(SP_QW))));

  // R7: bypass moves the whole count and counts nothing
  a_r7_bypass_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bypass) |-> ((burst == req_qwc) && !count_en));

  // R6: a stray ring write is never counted
  a_r6_stray_uncounted: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && stray) |-> (in_ring && !count_en));
endmodule

// File: tb/ring_wrap_bench.sv
module ring_wrap_bench;
  localparam int AW = 32;
  localparam int QW = 16;
  localparam int SW = 14;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_madr = '0;
  logic [SW-1:0] req_sadr = '0;
  logic [QW-1:0] req_qwc = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [QW-1:0] out_burst, out_remain;
  logic [AW-1:0] out_madr_next;
  logic [SW-1:0] out_sadr_next;
  logic          out_in_ring, out_stray;
  logic [TW-1:0] ring_total, resume_qwc;
  logic          resume_pulse;

  always #10 clk = ~clk;

  ring_wrap u_ring_wrap (.*);

  typedef struct {
    logic [QW-1:0] burst, remain;
    logic [AW-1:0] madr;
    logic [SW-1:0] sadr;
    logic          in_ring, stray, pulse;
    logic [TW-1:0] rqwc, total;
  } exp_t;

  exp_t          q[$];
  int            checks = 0, errors = 0;
  logic [AW-1:0] m_base = '0, m_mask = '0;
  logic [TW-1:0] m_total = '0;
  bit            seen = 0;
  bit            prev_stall = 0;
  logic [AW-1:0] prev_madr;
  logic [QW-1:0] prev_burst;
  bit            done = 0;
  bit            rnd_ready = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic cfg(input logic sel, input logic [AW-1:0] val);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(posedge clk); #2;
    cfg_we = 1'b0;
    if (sel) m_mask = val & ~AW'(15); else m_base = val & ~AW'(15);
  endtask

  // driver: computes the expected result from the requirements and queues it
  task automatic send(input logic [AW-1:0] madr_i, input logic [SW-1:0] sadr_i, input logic [QW-1:0] qwc);
    exp_t e;
    logic [AW-1:0] madr;
    logic [SW-1:0] sadr;
    logic [AW:0]   lim;
    logic [AW-1:0] adv;
    logic [TW-1:0] sum;
    int room;
    bit inr, byp, cnt;
    madr = madr_i & ~AW'(15);
    sadr = sadr_i & ~SW'(15);
    lim  = {1'b0, m_base} + {1'b0, m_mask} + 33'd16;
    inr  = (madr >= m_base) && ({1'b0, madr} < lim);
    byp  = inr && (m_mask == 0);
    room = 1024 - int'(sadr[13:4]);
    if (byp) e.burst = qwc;
    else e.burst = (int'(qwc) < room) ? qwc : QW'(room);
    e.remain  = qwc - e.burst;
    adv       = madr + AW'(e.burst) * 16;
    e.madr    = (inr && !byp) ? m_base + (adv & m_mask) : adv;
    e.sadr    = SW'((int'(sadr) + int'(e.burst) * 16) & 16'h3FFF);
    e.in_ring = inr;
    e.stray   = inr && !byp && ((madr & ~m_mask) != m_base);
    cnt       = inr && !byp && !e.stray;
    sum       = m_total + (cnt ? TW'(e.burst) : '0);
    if (e.remain == 0 && sum != 0) begin
      e.pulse = 1'b1; e.rqwc = sum; m_total = '0;
    end else begin
      e.pulse = 1'b0; e.rqwc = '0; m_total = sum;
    end
    e.total = m_total;
    q.push_back(e);
    @(posedge clk); #2;
    req_valid = 1'b1; req_madr = madr_i; req_sadr = sadr_i; req_qwc = qwc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  // monitor: compares each new result in the first cycle it appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk("R11 held valid", out_valid, 1);
        chk("R11 held madr", out_madr_next, prev_madr);
        chk("R11 held burst", out_burst, prev_burst);
      end
      chk("R11 ready rule", req_ready, !out_valid || out_ready);
      if (out_valid && !seen) begin
        if (q.size() == 0) begin
          chk("R11 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R4 burst", out_burst, e.burst);
          chk("R4 remain", out_remain, e.remain);
          chk("R5 next madr", out_madr_next, e.madr);
          chk("R8 next sadr", out_sadr_next, e.sadr);
          chk("R3 in ring", out_in_ring, e.in_ring);
          chk("R6 stray", out_stray, e.stray);
          chk("R10 resume pulse", resume_pulse, e.pulse);
          if (e.pulse) chk("R10 resume qwc", resume_qwc, e.rqwc);
          chk("R9 total", ring_total, e.total);
        end
        seen = 1;
      end else begin
        chk("R10 pulse one cycle", resume_pulse, 0);
      end
      if (out_valid && out_ready) seen = 0;
      prev_stall = out_valid && !out_ready;
      prev_madr  = out_madr_next;
      prev_burst = out_burst;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_up();
  end

  always @(posedge clk) begin
    if (rnd_ready) begin
      #2 out_ready = ($urandom % 3) != 0;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 total", ring_total, 0);
    chk("R1 pulse", resume_pulse, 0);
    chk("R1 ready", req_ready, 1);

    // R2/R3/R5: 16 KB ring, fold-back past the ring end, full count done
    cfg(1'b0, 32'h0010_0000);
    cfg(1'b1, 32'h0000_3FF0);
    send(32'h0010_3F00, 14'h0000, 16'd32);
    // R3: window edges, last in-ring address and first beyond
    send(32'h0010_3FF0, 14'h0000, 16'd1);
    send(32'h0010_4000, 14'h0000, 16'd1);
    send(32'h000F_FFF0, 14'h0000, 16'd1);
    // R4/R8: burst clipped at scratchpad end, then the rest; R9/R10 total across two
    send(32'h0010_0100, 14'h3F80, 16'd20);
    send(32'h0010_0180, 14'h0000, 16'd12);
    // R12: zero count
    send(32'h0010_0200, 14'h0120, 16'd0);
    // R2: low nibble of writes dropped, misaligned base gives R6 stray
    cfg(1'b0, 32'h0010_100F);
    send(32'h0010_2000, 14'h0010, 16'd4);
    send(32'h0010_1000, 14'h0000, 16'd3);
    // R7: zero mask bypass, with sadr wrap R8
    cfg(1'b1, 32'h0000_0000);
    send(32'h0010_1000, 14'h3FF0, 16'd40);
    send(32'h0010_1010, 14'h3FF7, 16'd2);

    // R11: back-pressure while a second request waits
    cfg(1'b0, 32'h0020_0000);
    cfg(1'b1, 32'h0000_0FF0);
    @(posedge clk); #2 out_ready = 1'b0;
    fork
      begin
        send(32'h0020_0F80, 14'h0400, 16'd16);
        send(32'h0020_0010, 14'h0500, 16'd2);
      end
      begin
        repeat (6) @(posedge clk);
        #2 out_ready = 1'b1;
      end
    join

    // randomized traffic with random back-pressure
    rnd_ready = 1;
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      a = 32'h0020_0000 + AW'($urandom % 32'h1400) - 32'h200;
      send(a, SW'($urandom), QW'($urandom % 1400));
    end
    rnd_ready = 0;
    @(posedge clk); #2 out_ready = 1'b1;
    repeat (5) @(posedge clk);
    chk("R11 queue drained", q.size(), 0);
    done = 1;
    finish_up();
  end
endmodule